// File: doc/BRIEF.md
# Thread-Aware L1 Way Predictor

This block is the speculative fast path in front of a set-associative L1 data cache that two hardware threads share. For every way of every set it keeps a valid flag, a short partial tag taken from the linear address, and the number of the thread that brought the line in. On each load it reads the indexed set and compares the entries against the load. One cycle later it reports whether the load is predicted to hit and, if so, which way. The slow path later confirms or cancels the prediction with the full physical tag.

A thread match is normally required as well as a partial-tag match, because the two threads may map the same linear address to different physical lines. A small context unit compares the two threads' page-table base values and paging-mode codes and registers the result. A mode input selects one of two policies. In adaptive mode, when both threads run with identical translation state, the thread comparison is waived, so either thread can hit on a line the other brought in. In shared mode the thread comparison always applies. Line fills write an entry into a named way of the indexed set.

Top module: `thread_way_predictor`

## Requirements
- R1: While `rst_n` is low and after it rises, `pred_valid` and `pred_hit` are 0, and every entry is invalid, so every lookup made before the first fill reports a miss.
- R2: A lookup selects its set with address bits 10:6 and compares address bits 15:11 against the stored partial tag. A valid entry in that set with an equal partial tag is a tag match, whatever the other address bits are. A different set or a different partial tag does not match.
- R3: With `mode_sel` = 1 (shared), a hit also requires the entry's stored thread bit to equal `lk_tid`.
- R4: With `mode_sel` = 0 (adaptive), when both threads have equal page-table base values and equal paging codes, the thread bit is ignored and a tag match alone hits.
- R5: With `mode_sel` = 0, when the page-table base values or the paging codes differ, the thread bit must match as in shared mode.
- R6: The translation comparison is registered. A change to `t0_ptb`, `t1_ptb`, `t0_pmode` or `t1_pmode` does not affect a lookup made in the same cycle. It affects lookups from the following cycle onward.
- R7: When several ways hit, `pred_way` is the lowest-numbered hitting way. On a miss, `pred_way` is 0.
- R8: The result of a lookup appears on the rising edge that samples `lk_valid` = 1 and holds for one cycle. `pred_valid` is 1 exactly in the cycle after a lookup, and `pred_hit` is 0 whenever `pred_valid` is 0.
- R9: A fill writes the partial tag (bits 15:11 of `fill_addr`), `fill_tid` and a set valid bit into way `fill_way` of set `fill_addr[10:6]`. Whatever that way held before is replaced.
- R10: A lookup and a fill to the same set in the same cycle: the lookup sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | 0 = adaptive, 1 = shared |
| t0_ptb | input | 32 | Thread 0 page-table base |
| t0_pmode | input | 2 | Thread 0 paging-mode code |
| t1_ptb | input | 32 | Thread 1 page-table base |
| t1_pmode | input | 2 | Thread 1 paging-mode code |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup linear address |
| lk_tid | input | 1 | Requesting thread |
| fill_valid | input | 1 | Line fill write |
| fill_addr | input | 32 | Fill linear address |
| fill_way | input | 2 | Way to write |
| fill_tid | input | 1 | Thread that owns the filled line |
| pred_valid | output | 1 | A lookup result is present |
| pred_hit | output | 1 | Speculative hit |
| pred_way | output | 2 | Predicted way |

## Verification
The bench builds the block with its default parameters: four ways, 32 sets, and a five-bit partial tag above a five-bit set index. With four ways, a set can hold the same partial tag in non-adjacent ways under different owners, so the lowest-way rule can be tested separately under each mode. The 32-bit address lets the tests vary the high and low bits that must be ignored. The 32-bit base registers and 2-bit paging codes let the context be broken by either field alone, both in the cycle of the change and in the cycle after it.

// File: rtl/twp_pkg.sv
package twp_pkg;
   // Policy applied to the per-way thread comparison
   typedef enum logic {
      MODE_ADAPTIVE = 1'b0,
      MODE_SHARED   = 1'b1
   } twp_mode_e;
endpackage

// File: rtl/twp_ctx_unit.sv
// Registered comparison of the two threads' translation state.
module twp_ctx_unit #(
   parameter int PTB_W   = 32,
   parameter int PMODE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PTB_W-1:0]   ptb_a,
   input  logic [PMODE_W-1:0] pm_a,
   input  logic [PTB_W-1:0]   ptb_b,
   input  logic [PMODE_W-1:0] pm_b,
   output logic               ctx_same
);
   localparam int CMP_W = PTB_W + PMODE_W;

   logic [CMP_W-1:0] side_a, side_b;
   logic             eq_now;

   assign side_a = {ptb_a, pm_a};
   assign side_b = {ptb_b, pm_b};
   assign eq_now = (side_a == side_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctx_same <= 1'b0;
      else        ctx_same <= eq_now;
   end
endmodule

// File: rtl/twp_tag_store.sv
// Per-way arrays of valid, partial tag and owner thread.
module twp_tag_store #(
   parameter int WAYS   = 4,
   parameter int SETS   = 32,
   parameter int PTAG_W = 5,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SET_W-1:0]         rd_set,
   output logic [WAYS-1:0]          rd_v,
   output logic [WAYS*PTAG_W-1:0]   rd_tag,
   output logic [WAYS-1:0]          rd_tid,
   input  logic                     wr_en,
   input  logic [SET_W-1:0]         wr_set,
   input  logic [WAY_W-1:0]         wr_way,
   input  logic [PTAG_W-1:0]        wr_tag,
   input  logic                     wr_tid
);
   initial begin
      if (SETS != (1 << SET_W)) $fatal(1, "SETS must be a power of two");
      if (WAYS != (1 << WAY_W)) $fatal(1, "WAYS must be a power of two");
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic              v_q   [SETS];
      logic [PTAG_W-1:0] tag_q [SETS];
      logic              tid_q [SETS];
      logic              wr_hit;

      assign wr_hit = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) v_q[s] <= 1'b0;
         end else if (wr_hit) begin
            v_q[wr_set] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_hit) begin
            tag_q[wr_set] <= wr_tag;
            tid_q[wr_set] <= wr_tid;
         end
      end

      // Read reflects the contents before any write on this edge
      assign rd_v[w]                      = v_q[rd_set];
      assign rd_tag[w*PTAG_W +: PTAG_W]   = tag_q[rd_set];
      assign rd_tid[w]                    = tid_q[rd_set];
   end
endmodule

// File: rtl/twp_way_match.sv
// Per-way compare and lowest-way priority select.
module twp_way_match #(
   parameter int WAYS   = 4,
   parameter int PTAG_W = 5,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]        rd_v,
   input  logic [WAYS*PTAG_W-1:0] rd_tag,
   input  logic [WAYS-1:0]        rd_tid,
   input  logic [PTAG_W-1:0]      lk_tag,
   input  logic                   lk_tid,
   input  logic                   tid_waive,
   output logic                   any_hit,
   output logic [WAY_W-1:0]       hit_way
);
   logic [WAYS-1:0] way_hit;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      logic tag_eq, tid_ok;
      assign tag_eq     = (rd_tag[w*PTAG_W +: PTAG_W] == lk_tag);
      assign tid_ok     = tid_waive || (rd_tid[w] == lk_tid);
      assign way_hit[w] = rd_v[w] && tag_eq && tid_ok;
   end

   assign any_hit = |way_hit;

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_hit[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/thread_way_predictor.sv
module thread_way_predictor
   import twp_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WAYS     = 4,
   parameter int SETS     = 32,
   parameter int LINE_LSB = 6,
   parameter int PTAG_LSB = 11,
   parameter int PTAG_W   = 5,
   parameter int PTB_W    = 32,
   parameter int PMODE_W  = 2,
   localparam int SET_W   = $clog2(SETS),
   localparam int WAY_W   = $clog2(WAYS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_sel,
   input  logic [PTB_W-1:0]   t0_ptb,
   input  logic [PMODE_W-1:0] t0_pmode,
   input  logic [PTB_W-1:0]   t1_ptb,
   input  logic [PMODE_W-1:0] t1_pmode,
   input  logic               lk_valid,
   input  logic [ADDR_W-1:0]  lk_addr,
   input  logic               lk_tid,
   input  logic               fill_valid,
   input  logic [ADDR_W-1:0]  fill_addr,
   input  logic [WAY_W-1:0]   fill_way,
   input  logic               fill_tid,
   output logic               pred_valid,
   output logic               pred_hit,
   output logic [WAY_W-1:0]   pred_way
);
   initial begin
      if (PTAG_LSB < LINE_LSB + SET_W) $fatal(1, "partial tag overlaps set index");
      if (ADDR_W < PTAG_LSB + PTAG_W)  $fatal(1, "address too narrow for partial tag");
      if (WAYS < 2)                    $fatal(1, "at least two ways required");
   end

   logic [SET_W-1:0]       lk_set, fl_set;
   logic [PTAG_W-1:0]      lk_tag, fl_tag;
   logic                   ctx_same;
   logic                   tid_waive;
   logic [WAYS-1:0]        rd_v, rd_tid;
   logic [WAYS*PTAG_W-1:0] rd_tag;
   logic                   any_hit;
   logic [WAY_W-1:0]       hit_way;
   logic                   addr_unused;

   assign lk_set = lk_addr[LINE_LSB +: SET_W];
   assign lk_tag = lk_addr[PTAG_LSB +: PTAG_W];
   assign fl_set = fill_addr[LINE_LSB +: SET_W];
   assign fl_tag = fill_addr[PTAG_LSB +: PTAG_W];
   assign addr_unused = ^{lk_addr, fill_addr};

   twp_ctx_unit #(.PTB_W(PTB_W), .PMODE_W(PMODE_W)) i_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptb_a    (t0_ptb),
      .pm_a     (t0_pmode),
      .ptb_b    (t1_ptb),
      .pm_b     (t1_pmode),
      .ctx_same (ctx_same)
   );

   assign tid_waive = (twp_mode_e'(mode_sel) == MODE_ADAPTIVE) && ctx_same;

   twp_tag_store #(.WAYS(WAYS), .SETS(SETS), .PTAG_W(PTAG_W)) i_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_set (lk_set),
      .rd_v   (rd_v),
      .rd_tag (rd_tag),
      .rd_tid (rd_tid),
      .wr_en  (fill_valid),
      .wr_set (fl_set),
      .wr_way (fill_way),
      .wr_tag (fl_tag),
      .wr_tid (fill_tid)
   );

   twp_way_match #(.WAYS(WAYS), .PTAG_W(PTAG_W)) i_match (
      .rd_v      (rd_v),
      .rd_tag    (rd_tag),
      .rd_tid    (rd_tid),
      .lk_tag    (lk_tag),
      .lk_tid    (lk_tid),
      .tid_waive (tid_waive),
      .any_hit   (any_hit),
      .hit_way   (hit_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_valid <= 1'b0;
         pred_hit   <= 1'b0;
         pred_way   <= '0;
      end else begin
         pred_valid <= lk_valid;
         pred_hit   <= lk_valid && any_hit;
         pred_way   <= (lk_valid && any_hit) ? hit_way : '0;
      end
   end
endmodule

// File: rtl/twp_chk.sv
module twp_chk #(
   parameter int PTB_W   = 32,
   parameter int PMODE_W = 2,
   parameter int WAY_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PTB_W-1:0]   t0_ptb,
   input logic [PMODE_W-1:0] t0_pmode,
   input logic [PTB_W-1:0]   t1_ptb,
   input logic [PMODE_W-1:0] t1_pmode,
   input logic               ctx_same,
   input logic               lk_valid,
   input logic               pred_valid,
   input logic               pred_hit,
   input logic [WAY_W-1:0]   pred_way
);
   logic xl_eq;
   assign xl_eq = (t0_ptb == t1_ptb) && (t0_pmode == t1_pmode);

   // R8
   lookup_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> pred_valid);

   // R8
   idle_gives_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !pred_valid);

   // R8
   hit_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_valid |-> !pred_hit);

   // R7
   miss_way_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && !pred_hit) |-> (pred_way == '0));

   // R6
   ctx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_eq |=> ctx_same);

   // R6
   ctx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_eq |=> !ctx_same);
endmodule

bind thread_way_predictor twp_chk #(
   .PTB_W(PTB_W), .PMODE_W(PMODE_W), .WAY_W(WAY_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .t0_ptb     (t0_ptb),
   .t0_pmode   (t0_pmode),
   .t1_ptb     (t1_ptb),
   .t1_pmode   (t1_pmode),
   .ctx_same   (ctx_same),
   .lk_valid   (lk_valid),
   .pred_valid (pred_valid),
   .pred_hit   (pred_hit),
   .pred_way   (pred_way)
);

// File: tb/test_thread_way_predictor.sv
module test_thread_way_predictor;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode_sel;
   logic [31:0] t0_ptb, t1_ptb;
   logic [1:0]  t0_pmode, t1_pmode;
   logic        lk_valid, lk_tid;
   logic [31:0] lk_addr;
   logic        fill_valid, fill_tid;
   logic [31:0] fill_addr;
   logic [1:0]  fill_way;
   logic        pred_valid, pred_hit;
   logic [1:0]  pred_way;

   always #2 clk = ~clk;

   thread_way_predictor i_thread_way_predictor (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .t0_ptb(t0_ptb), .t0_pmode(t0_pmode), .t1_ptb(t1_ptb), .t1_pmode(t1_pmode),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_tid(lk_tid),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way), .fill_tid(fill_tid),
      .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_way(pred_way)
   );

   typedef struct {
      logic       v;
      logic       h;
      logic [1:0] w;
      string      req;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   mon_en = 0;
   bit   done = 0;

   // Reference state built from the requirements
   logic       ref_v   [32][4];
   logic [4:0] ref_tag [32][4];
   logic       ref_tid [32][4];
   logic       ref_ctx;

   function automatic logic [31:0] mk(input logic [15:0] hi, input logic [4:0] tag,
                                      input logic [4:0] set, input logic [5:0] lo);
      return {hi, tag, set, lo};
   endfunction

   task automatic tick(input string req);
      exp_t e;
      logic waive;
      int   s;
      e.v = lk_valid; e.h = 1'b0; e.w = 2'd0; e.req = req;
      if (lk_valid) begin
         s = int'(lk_addr[10:6]);
         waive = !mode_sel && ref_ctx;
         for (int w = 3; w >= 0; w--) begin
            if (ref_v[s][w] && ref_tag[s][w] == lk_addr[15:11] &&
                (waive || ref_tid[s][w] == lk_tid)) begin
               e.h = 1'b1; e.w = 2'(w);
            end
         end
      end
      q.push_back(e);
      @(posedge clk);
      if (fill_valid) begin
         ref_v  [int'(fill_addr[10:6])][int'(fill_way)] = 1'b1;
         ref_tag[int'(fill_addr[10:6])][int'(fill_way)] = fill_addr[15:11];
         ref_tid[int'(fill_addr[10:6])][int'(fill_way)] = fill_tid;
      end
      ref_ctx = (t0_ptb == t1_ptb) && (t0_pmode == t1_pmode);
      @(negedge clk);
      lk_valid   = 1'b0;
      fill_valid = 1'b0;
   endtask

   task automatic set_look(input logic [31:0] a, input logic tid);
      lk_valid = 1'b1; lk_addr = a; lk_tid = tid;
   endtask

   task automatic set_fill(input logic [31:0] a, input logic [1:0] way, input logic tid);
      fill_valid = 1'b1; fill_addr = a; fill_way = way; fill_tid = tid;
   endtask

   task automatic look(input logic [31:0] a, input logic tid, input string req);
      set_look(a, tid);
      tick(req);
   endtask

   task automatic fill(input logic [31:0] a, input logic [1:0] way, input logic tid);
      set_fill(a, way, tid);
      tick("R9");
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Monitor: compares each cycle's result against the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_en) begin
            if (q.size() == 0) begin
               if (pred_valid) begin
                  n_cmp++; n_bad++;
                  $display("FAIL R8: pred_valid=%0b expected 0 (no lookup queued)", pred_valid);
               end
            end else begin
               exp_t e;
               e = q.pop_front();
               n_cmp++;
               if (!e.v) begin
                  if (pred_valid !== 1'b0 || pred_hit !== 1'b0) begin
                     n_bad++;
                     $display("FAIL %s: idle cycle valid/hit=%0b/%0b expected 0/0",
                              e.req, pred_valid, pred_hit);
                  end
               end else if (pred_valid !== 1'b1 || pred_hit !== e.h || pred_way !== e.w) begin
                  n_bad++;
                  $display("FAIL %s: valid/hit/way=%0b/%0b/%0d expected 1/%0b/%0d",
                           e.req, pred_valid, pred_hit, pred_way, e.h, e.w);
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 32; s++)
         for (int w = 0; w < 4; w++) begin
            ref_v[s][w] = 1'b0; ref_tag[s][w] = '0; ref_tid[s][w] = 1'b0;
         end
      ref_ctx = 1'b0;
      rst_n = 1'b0; mode_sel = 1'b1;
      t0_ptb = 32'h0000_1000; t1_ptb = 32'h0000_1000;
      t0_pmode = 2'b01; t1_pmode = 2'b01;
      lk_valid = 1'b0; lk_addr = '0; lk_tid = 1'b0;
      fill_valid = 1'b0; fill_addr = '0; fill_way = '0; fill_tid = 1'b0;
      repeat (3) @(negedge clk);
      n_cmp++;
      if (pred_valid !== 1'b0 || pred_hit !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: in reset valid/hit=%0b/%0b expected 0/0", pred_valid, pred_hit);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_cmp++;
      if (pred_valid !== 1'b0 || pred_hit !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: after reset valid/hit=%0b/%0b expected 0/0", pred_valid, pred_hit);
      end
      mon_en = 1;

      // R1: empty store misses
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b0, "R1");
      look(mk(16'h7, 5'h00, 5'd0, 6'h0), 1'b1, "R1");
      tick("R8");

      // R2 / R3 in shared mode
      fill(mk(16'h0, 5'h15, 5'd3, 6'h0), 2'd2, 1'b0);
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b0, "R2");
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b1, "R3");
      look(mk(16'h0, 5'h14, 5'd3, 6'h0), 1'b0, "R2");
      look(mk(16'h0, 5'h15, 5'd4, 6'h0), 1'b0, "R2");
      look(mk(16'hbeef, 5'h15, 5'd3, 6'h3f), 1'b0, "R2");

      // R4 / R5 / R6 in adaptive mode
      mode_sel = 1'b0;
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b1, "R4");
      t1_ptb = 32'h0000_2000;
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b1, "R6");
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b1, "R5");
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b0, "R5");
      t1_ptb = 32'h0000_1000;
      tick("R6");
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b1, "R4");
      t1_pmode = 2'b10;
      tick("R6");
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b1, "R5");
      t1_pmode = 2'b01;
      tick("R6");
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b1, "R6");

      // R7: lowest hitting way
      mode_sel = 1'b1;
      fill(mk(16'h0, 5'h0a, 5'd5, 6'h0), 2'd3, 1'b1);
      fill(mk(16'h0, 5'h0a, 5'd5, 6'h0), 2'd1, 1'b1);
      look(mk(16'h0, 5'h0a, 5'd5, 6'h0), 1'b1, "R7");
      fill(mk(16'h0, 5'h0a, 5'd5, 6'h0), 2'd0, 1'b0);
      look(mk(16'h0, 5'h0a, 5'd5, 6'h0), 1'b1, "R7");
      look(mk(16'h0, 5'h0a, 5'd5, 6'h0), 1'b0, "R7");
      mode_sel = 1'b0;
      look(mk(16'h0, 5'h0a, 5'd5, 6'h0), 1'b1, "R7");

      // R10: same-cycle fill and lookup to one set
      mode_sel = 1'b1;
      set_look(mk(16'h0, 5'h03, 5'd7, 6'h0), 1'b0);
      set_fill(mk(16'h0, 5'h03, 5'd7, 6'h0), 2'd1, 1'b0);
      tick("R10");
      look(mk(16'h0, 5'h03, 5'd7, 6'h0), 1'b0, "R10");

      // R9: overwrite of a way
      fill(mk(16'h0, 5'h01, 5'd3, 6'h0), 2'd2, 1'b0);
      look(mk(16'h0, 5'h15, 5'd3, 6'h0), 1'b0, "R9");
      look(mk(16'h0, 5'h01, 5'd3, 6'h0), 1'b0, "R9");

      tick("R8");
      tick("R8");
      repeat (2) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule